// File: doc/BRIEF.md
# Banked register-file address unit

This unit turns a 7-bit operand address into a 9-bit physical byte address for an 8-bit register file. The file has 512 bytes, split into four banks of 128. Two addressing paths share the operand input. A direct operand sits inside the bank chosen by two bank bits in the status byte. An operand equal to the redirect offset is instead replaced by the pointer byte, extended by one more status bit. Through the redirect offset, software can walk tables that span two banks without touching the bank bits.

Three locations are not storage. They appear in every bank at the same offsets: the redirect location, the status byte and the pointer byte. Software can therefore reach them whatever the bank bits hold. The status byte holds the bank bits and three arithmetic flags, and an external ALU can refresh the flags alongside any access. Reads are registered, so the byte appears one cycle after the request. Instruction decode stays outside the unit.

Top module: `bankreg_addr_unit`

## Requirements
- R1: After reset, the status byte reads 0x18 and the pointer byte reads 0x00.
- R2: An operand other than offset 0x00 maps to physical address {status[6], status[5], operand}. Status bit 6 is the upper bank bit and bit 5 the lower.
- R3: Operand 0x00 is the redirect location and maps to physical address {status[7], pointer[7:0]}. A read or write there reaches the byte at that address.
- R4: In every bank, offset 0x03 is the status byte and offset 0x04 is the pointer byte. Both are reachable by direct and redirected accesses.
- R5: read data appears on the clock edge after a cycle with rd_en high, and is held unchanged while rd_en is low.
- R6: When a redirected access lands on offset 0x00 of any bank, a read returns 0x00. A write there changes neither storage, the status byte nor the pointer byte.
- R7: With flag_we high, status bits 0 (carry), 1 (digit carry) and 2 (zero) take flag_in[0], flag_in[1] and flag_in[2]. The other status bits are unchanged, and a storage write in the same cycle still takes place.
- R8: An explicit write to the status byte in the same cycle as flag_we writes all eight bits from wr_data, and the flags are ignored.
- R9: A read and a write to the same address in one cycle return the byte held before the write.
- R10: phys_addr shows the physical address of the current operand in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_addr | input | 7 | Operand address field |
| rd_en | input | 1 | Read request |
| wr_en | input | 1 | Write request |
| wr_data | input | 8 | Write byte |
| flag_we | input | 1 | Flag refresh enable |
| flag_in | input | 3 | New zero, digit carry and carry flags |
| rd_data | output | 8 | Registered read byte |
| phys_addr | output | 9 | Current physical address |

## Verification
The hardest case to reach is the redirect loop, where the pointer selects offset 0 of some bank. A plain redirected access never gets there. The stimulus first writes the pointer through its mirrored offset, once with 0x00 and once with 0x80, and only then accesses operand 0x00. It then reads back the pointer, the status byte and the redirected byte to show that nothing moved. A second hard case is the three-way collision of a flag refresh with a write in the same cycle. The stimulus produces it once against storage and once against the status byte, to separate R7 from R8.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;
    localparam int DATA_W = 8;
    localparam int OFS_W  = 7;
    localparam int BANK_W = 2;
    localparam int ADDR_W = OFS_W + BANK_W;
    localparam int PTR_W  = OFS_W + 1;
    localparam int FLAG_W = 3;

    // status byte bit positions (behavioural: bank bits feed address former)
    localparam int ST_RP_LO = 5;
    localparam int ST_RP_HI = 6;
    localparam int ST_IRP   = 7;

    typedef enum logic [1:0] {
        TGT_MEM,
        TGT_STAT,
        TGT_PTR,
        TGT_VOID
    } tgt_e;
endpackage

// File: rtl/bankreg_addr_former.sv
module bankreg_addr_former
    import bankreg_pkg::*;
#(
    parameter logic [OFS_W-1:0] INDIR_OFS = 7'h00,
    parameter logic [OFS_W-1:0] STAT_OFS  = 7'h03,
    parameter logic [OFS_W-1:0] PTR_OFS   = 7'h04
) (
    input  logic [OFS_W-1:0]  op_addr,
    input  logic [BANK_W-1:0] bank_bits,
    input  logic              pair_bit,
    input  logic [PTR_W-1:0]  ptr,
    output logic [ADDR_W-1:0] eff_addr,
    output tgt_e              tgt
);
    logic             redirect;
    logic [OFS_W-1:0] eff_low;

    always_comb begin
        redirect = (op_addr == INDIR_OFS);
        if (redirect) begin
            eff_addr = {pair_bit, ptr};
        end else begin
            eff_addr = {bank_bits, op_addr};
        end
        eff_low = eff_addr[OFS_W-1:0];
        // offset INDIR_OFS can only come out of the redirect path here
        if (eff_low == INDIR_OFS) begin
            tgt = TGT_VOID;
        end else if (eff_low == STAT_OFS) begin
            tgt = TGT_STAT;
        end else if (eff_low == PTR_OFS) begin
            tgt = TGT_PTR;
        end else begin
            tgt = TGT_MEM;
        end
    end
endmodule

// File: rtl/bankreg_ctrl_regs.sv
module bankreg_ctrl_regs
    import bankreg_pkg::*;
#(
    parameter logic [DATA_W-1:0] STAT_RST = 8'h18,
    parameter logic [PTR_W-1:0]  PTR_RST  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  tgt_e              tgt,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              flag_we,
    input  logic [FLAG_W-1:0] flag_in,
    output logic [DATA_W-1:0] stat_q,
    output logic [PTR_W-1:0]  ptr_q
);
    logic stat_wr;
    logic ptr_wr;

    always_comb begin
        stat_wr = wr_en && (tgt == TGT_STAT);
        ptr_wr  = wr_en && (tgt == TGT_PTR);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= STAT_RST;
        end else if (stat_wr) begin
            stat_q <= wr_data;
        end else if (flag_we) begin
            stat_q[FLAG_W-1:0] <= flag_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= PTR_RST;
        end else if (ptr_wr) begin
            ptr_q <= wr_data[PTR_W-1:0];
        end
    end
endmodule

// File: rtl/bankreg_byte_store.sv
module bankreg_byte_store #(
    parameter int AW = 9,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
    end

    assign rdata = cells[addr];
endmodule

// File: rtl/bankreg_addr_unit.sv
module bankreg_addr_unit
    import bankreg_pkg::*;
#(
    parameter logic [OFS_W-1:0]  INDIR_OFS = 7'h00,
    parameter logic [OFS_W-1:0]  STAT_OFS  = 7'h03,
    parameter logic [OFS_W-1:0]  PTR_OFS   = 7'h04,
    parameter logic [DATA_W-1:0] STAT_RST  = 8'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFS_W-1:0]  op_addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              flag_we,
    input  logic [FLAG_W-1:0] flag_in,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] phys_addr
);
    logic [DATA_W-1:0] stat_q;
    logic [PTR_W-1:0]  ptr_q;
    logic [DATA_W-1:0] mem_rdata;
    logic              mem_we;
    tgt_e              tgt;

    bankreg_addr_former #(
        .INDIR_OFS(INDIR_OFS),
        .STAT_OFS (STAT_OFS),
        .PTR_OFS  (PTR_OFS)
    ) u_former (
        .op_addr  (op_addr),
        .bank_bits(stat_q[ST_RP_HI:ST_RP_LO]),
        .pair_bit (stat_q[ST_IRP]),
        .ptr      (ptr_q),
        .eff_addr (phys_addr),
        .tgt      (tgt)
    );

    bankreg_ctrl_regs #(
        .STAT_RST(STAT_RST)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .tgt    (tgt),
        .wr_data(wr_data),
        .flag_we(flag_we),
        .flag_in(flag_in),
        .stat_q (stat_q),
        .ptr_q  (ptr_q)
    );

    assign mem_we = wr_en && (tgt == TGT_MEM);

    bankreg_byte_store #(
        .AW(ADDR_W),
        .DW(DATA_W)
    ) u_store (
        .clk  (clk),
        .we   (mem_we),
        .addr (phys_addr),
        .wdata(wr_data),
        .rdata(mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            unique case (tgt)
                TGT_MEM:  rd_data <= mem_rdata;
                TGT_STAT: rd_data <= stat_q;
                TGT_PTR:  rd_data <= {{(DATA_W-PTR_W){1'b0}}, ptr_q};
                TGT_VOID: rd_data <= '0;
            endcase
        end
    end
endmodule

// File: rtl/bankreg_addr_unit_chk.sv
module bankreg_addr_unit_chk
    import bankreg_pkg::*;
#(
    parameter logic [OFS_W-1:0] INDIR_OFS = 7'h00,
    parameter logic [OFS_W-1:0] STAT_OFS  = 7'h03,
    parameter logic [OFS_W-1:0] PTR_OFS   = 7'h04
) (
    input logic              clk,
    input logic              rst_n,
    input logic [OFS_W-1:0]  op_addr,
    input logic              rd_en,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              flag_we,
    input logic [FLAG_W-1:0] flag_in,
    input logic [DATA_W-1:0] rd_data,
    input logic [ADDR_W-1:0] phys_addr,
    input logic [DATA_W-1:0] stat_q,
    input logic [PTR_W-1:0]  ptr_q
);
    logic             via_ptr;
    logic [OFS_W-1:0] eff_low;
    logic             loop_hit;
    logic             stat_hit;
    logic             ptr_hit;

    assign via_ptr  = (op_addr == INDIR_OFS);
    assign eff_low  = phys_addr[OFS_W-1:0];
    assign loop_hit = via_ptr && (eff_low == INDIR_OFS);
    assign stat_hit = !loop_hit && (eff_low == STAT_OFS);
    assign ptr_hit  = !loop_hit && (eff_low == PTR_OFS);

    // R2
    bank_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !via_ptr |-> (phys_addr == {stat_q[ST_RP_HI:ST_RP_LO], op_addr}));

    // R3
    ptr_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        via_ptr |-> (phys_addr == {stat_q[ST_IRP], ptr_q}));

    // R5
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    // R6
    loop_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && loop_hit) |=> (rd_data == '0));

    // R6
    loop_write_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && loop_hit && !flag_we) |=> ($stable(stat_q) && $stable(ptr_q)));

    // R7
    flag_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && !(wr_en && stat_hit)) |=> (stat_q[FLAG_W-1:0] == $past(flag_in)));

    // R8
    stat_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && stat_hit) |=> (stat_q == $past(wr_data)));

    // R4
    ptr_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ptr_hit) |=> (ptr_q == $past(wr_data[PTR_W-1:0])));
endmodule

bind bankreg_addr_unit bankreg_addr_unit_chk #(
    .INDIR_OFS(INDIR_OFS),
    .STAT_OFS (STAT_OFS),
    .PTR_OFS  (PTR_OFS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_addr  (op_addr),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .flag_we  (flag_we),
    .flag_in  (flag_in),
    .rd_data  (rd_data),
    .phys_addr(phys_addr),
    .stat_q   (stat_q),
    .ptr_q    (ptr_q)
);

// File: tb/bankreg_addr_unit_test.sv
module bankreg_addr_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] op_addr = '0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       flag_we = 1'b0;
    logic [2:0] flag_in = '0;
    logic [7:0] rd_data;
    logic [8:0] phys_addr;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic       rd_seen = 1'b0;

    always #5 clk = ~clk;

    bankreg_addr_unit uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_addr  (op_addr),
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .flag_we  (flag_we),
        .flag_in  (flag_in),
        .rd_data  (rd_data),
        .phys_addr(phys_addr)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compares each registered read byte with the scoreboard head
    always @(posedge clk) rd_seen <= rd_en && rst_n;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                check("R5 unexpected read", 16'(rd_data), 16'hFFFF);
            end else begin
                check(tag_q.pop_front(), 16'(rd_data), 16'(exp_q.pop_front()));
            end
        end
    end

    task automatic drive(input logic [6:0] a, input logic r, input logic w,
                         input logic [7:0] d, input logic fw, input logic [2:0] f);
        @(negedge clk);
        op_addr = a;
        rd_en   = r;
        wr_en   = w;
        wr_data = d;
        flag_we = fw;
        flag_in = f;
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        drive(a, 1'b0, 1'b1, d, 1'b0, 3'b000);
    endtask

    task automatic rd(input logic [6:0] a, input logic [7:0] e, input string tag);
        drive(a, 1'b1, 1'b0, 8'h00, 1'b0, 3'b000);
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        drive(7'h10, 1'b0, 1'b0, 8'h00, 1'b0, 3'b000);
    endtask

    task automatic phys(input logic [8:0] e, input string tag);
        #1;
        check(tag, 16'(phys_addr), 16'(e));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        rd(7'h03, 8'h18, "R1 status reset");
        rd(7'h04, 8'h00, "R1 pointer reset");
        // R2 / R10 direct path in three banks
        wr(7'h20, 8'hA5); phys(9'h020, "R10 bank0 addr");
        wr(7'h03, 8'h38);
        wr(7'h20, 8'h5A); phys(9'h0A0, "R2 bank1 addr");
        wr(7'h03, 8'h78);
        wr(7'h20, 8'hC3); phys(9'h1A0, "R2 bank3 addr");
        // R4 mirrored registers in bank 3
        rd(7'h03, 8'h78, "R4 status in bank3");
        wr(7'h04, 8'h20);
        rd(7'h04, 8'h20, "R4 pointer in bank3");
        wr(7'h03, 8'h18);
        rd(7'h20, 8'hA5, "R2 bank0 readback");
        // R3 redirect path
        rd(7'h00, 8'hA5, "R3 ptr 0x20"); phys(9'h020, "R3 ptr addr");
        wr(7'h04, 8'hA0);
        rd(7'h00, 8'h5A, "R3 ptr 0xA0");
        wr(7'h03, 8'h98);
        rd(7'h00, 8'hC3, "R3 pair bit"); phys(9'h1A0, "R3 pair addr");
        wr(7'h04, 8'h30);
        wr(7'h00, 8'h11); phys(9'h130, "R3 write addr");
        wr(7'h03, 8'h58);
        rd(7'h30, 8'h11, "R3 write via ptr");
        // R5 hold while idle
        idle(); idle(); idle();
        check("R5 hold", 16'(rd_data), 16'h0011);
        // R6 redirect loop
        wr(7'h04, 8'h00);
        rd(7'h00, 8'h00, "R6 loop read");
        wr(7'h00, 8'h77);
        rd(7'h04, 8'h00, "R6 ptr unchanged");
        rd(7'h03, 8'h58, "R6 status unchanged");
        wr(7'h04, 8'h80);
        rd(7'h00, 8'h00, "R6 loop read bank pair");
        wr(7'h04, 8'h83);
        rd(7'h00, 8'h58, "R4 status via ptr");
        // R7 flag refresh
        drive(7'h10, 1'b0, 1'b0, 8'h00, 1'b1, 3'b101);
        rd(7'h03, 8'h5D, "R7 flags only");
        drive(7'h21, 1'b0, 1'b1, 8'h44, 1'b1, 3'b010);
        rd(7'h03, 8'h5A, "R7 flags with write");
        rd(7'h21, 8'h44, "R7 write kept");
        // R8 explicit status write wins
        drive(7'h03, 1'b0, 1'b1, 8'h40, 1'b1, 3'b111);
        rd(7'h03, 8'h40, "R8 status priority");
        // R9 read-before-write
        drive(7'h21, 1'b1, 1'b1, 8'h99, 1'b0, 3'b000);
        exp_q.push_back(8'h44);
        tag_q.push_back("R9 old value");
        rd(7'h21, 8'h99, "R9 new value");
        idle(); idle();
        check("R5 queue drained", 16'(exp_q.size()), 16'h0000);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule